// File: doc/BRIEF.md
# High-Bit-Rate Audio Subpacket Assembler

This block gathers compressed audio samples carried at high bit rate (IEC 61937 bursts above 6.144 Mbps). The samples arrive on four serial-audio lanes, and each lane carries a left and a right slot. The block packs them into packets of four subpackets. Each subpacket holds one left and one right sample.

The block has two input modes.
- **Four-stream mode:** every accepted input beat carries a full packet. Each of the eight output slots takes its sample from whichever lane and slot its own route code names.
- **One-stream mode:** four successive lane-0 left/right pairs form one packet.

A one-shot resynchronisation control arms a search for the burst preamble. The first matching Pa/Pb pair then restarts the framing so that the preamble lands in subpacket 0.

A finished packet is held on the output with a valid flag until the consumer takes it. While the packet waits, the input is paused through its ready signal. Biphase-mark decoding is done outside the block. The block only checks that a biphase-mark mode has a master clock enabled.

Top module: `hbr_subpacket_assembler`

## Requirements
- R1: After reset, `outValid` is 0, `inReady` is 1 (when no configuration error is present), the alignment search is disarmed, and every route code is the identity.
- R2: In four-stream mode (`fourStream`=1), each accepted beat (`inValid` and `inReady` both 1 at a clock edge) produces a packet. `outValid` is 1 after that edge. Output slot k (bits k*SW+:SW) equals input sample c (bits c*SW+:SW), where c is slot k's route code. Code c means lane c/2, with left when c is even and right when c is odd. Output slot k means subpacket k/2, with left when k is even and right when k is odd.
- R3: The route codes reset to code k for slot k. A clock edge with `routeLoad`=1 loads slot k's code from `routeSel[3k+:3]`. The new codes apply to beats accepted after that edge.
- R4: In one-stream mode, four accepted beats fill subpackets 0, 1, 2 and 3 in order. Each beat supplies the lane-0 left and right samples (input slots 0 and 1). The packet becomes valid after the fourth beat's edge and not before. Switching to four-stream mode discards any partial packet.
- R5: A 0-to-1 change of `syncCtrl` arms the search. While armed in one-stream mode, a beat qualifies when its lane-0 left sample has top 16 bits 0xF872 (Pa) and its lane-0 right sample has top 16 bits 0x4E1F (Pb). That first qualifying beat discards the partial packet, is placed into subpacket 0, and disarms the search.
- R6: A 1-to-0 change of `syncCtrl`, or holding it at 1, does not arm the search. A Pa/Pb beat seen while disarmed is packed at the current phase.
- R7: After an alignment, bursts whose repetition period is a multiple of four beats keep Pa in subpacket 0 with no further trigger.
- R8: While `outValid`=1 and `outReady`=0, `outPacket` holds stable and `inReady` is 0. With `outReady`=1, a new beat may be accepted in the same cycle.
- R9: `cfgErr` equals `bpmMode` AND NOT `mclkEn`. While `cfgErr` is 1, `inReady` is 0.
- R10: In four-stream mode with `outReady` held at 1, `inReady` stays 1 and one packet is produced on every beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fourStream | input | 1 | 1 = four-stream mode, 0 = one-stream mode |
| bpmMode | input | 1 | Biphase-mark input mode selected |
| mclkEn | input | 1 | Master clock is present |
| syncCtrl | input | 1 | Resynchronisation control; acts on its rising change |
| routeLoad | input | 1 | Load route codes from `routeSel` |
| routeSel | input | 24 | Eight 3-bit route codes, slot k at bits 3k+:3 |
| inValid | input | 1 | Input beat present |
| inSamples | input | 8*SW | Input samples, lane l slot s at index 2l+s |
| inReady | output | 1 | Beat accepted at this edge if `inValid` is 1 |
| outValid | output | 1 | Packet present on `outPacket` |
| outPacket | output | 8*SW | Packet, subpacket n left at index 2n, right at 2n+1 |
| outReady | input | 1 | Consumer takes the packet |
| cfgErr | output | 1 | Biphase-mark mode selected without a master clock |

## Verification
A wrong framing phase or arming state shows at the ports as soon as the current packet completes. In one-stream mode that is within four beats: the Pa sample appears in a slot other than subpacket 0 left, or a packet is emitted one beat early or late. A wrong route code shows in the very next four-stream packet as a misplaced sample. A bad handshake state shows in the same cycle as a mismatch on `inReady` or `outValid`.

// File: rtl/hbr_pkg.sv
package hbr_pkg;
  localparam int SUBPKTS = 4;
  localparam int SLOTS   = 2 * SUBPKTS;
  localparam int SELW    = $clog2(SLOTS);
  localparam logic [15:0] SYNC_PA = 16'hF872;
  localparam logic [15:0] SYNC_PB = 16'h4E1F;

  typedef struct packed {
    logic       beat;       // sample beat accepted this cycle
    logic       four;       // four-stream mode
    logic [1:0] slot;       // subpacket receiving the lane-0 pair (one-stream)
    logic       emit;       // packet completes this cycle
    logic       routeLoad;  // reload route codes
  } hbrStrobe_t;
endpackage

// File: rtl/hbr_ctrl.sv
module hbr_ctrl
  import hbr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       outReady,
  input  logic       fourStream,
  input  logic       bpmMode,
  input  logic       mclkEn,
  input  logic       syncCtrl,
  input  logic       routeLoad,
  input  logic       syncHit,
  output logic       inReady,
  output logic       outValid,
  output logic       cfgErr,
  output hbrStrobe_t strb
);
  logic [1:0] phase;
  logic [1:0] slotEff;
  logic       armed, syncPrev, outValidQ;
  logic       beat, syncRise, align, emit;

  assign cfgErr   = bpmMode & ~mclkEn;
  assign inReady  = ~cfgErr & (~outValidQ | outReady);
  assign beat     = inValid & inReady;
  assign syncRise = syncCtrl & ~syncPrev;
  assign align    = beat & ~fourStream & armed & syncHit;
  assign slotEff  = align ? 2'd0 : phase;
  assign emit     = beat & (fourStream | (slotEff == 2'd3));
  assign outValid = outValidQ;

  always_comb begin
    strb.beat      = beat;
    strb.four      = fourStream;
    strb.slot      = slotEff;
    strb.emit      = emit;
    strb.routeLoad = routeLoad;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= 2'd0;
      armed     <= 1'b0;
      syncPrev  <= 1'b0;
      outValidQ <= 1'b0;
    end else begin
      syncPrev  <= syncCtrl;
      outValidQ <= emit | (outValidQ & ~outReady);
      if (fourStream)
        phase <= 2'd0;
      else if (beat)
        phase <= slotEff + 2'd1;
      if (syncRise)
        armed <= 1'b1;
      else if (align)
        armed <= 1'b0;
    end
  end

  // R6: without a rising change of the control, a disarmed search stays disarmed
  a_r6_no_arm_without_rise: assert property (@(posedge clk) disable iff (!rstN)
    (!armed && !(syncCtrl && !syncPrev)) |=> !armed);
  // R5: an alignment beat restarts framing right after subpacket 0
  a_r5_align_restart: assert property (@(posedge clk) disable iff (!rstN)
    (align && !fourStream) |=> (phase == 2'd1 || fourStream));
  // R4: a one-stream beat that is not the fourth leaves no packet
  a_r4_no_early_packet: assert property (@(posedge clk) disable iff (!rstN)
    (beat && !fourStream && slotEff != 2'd3) |=> !outValidQ);
  // R2: every four-stream beat yields a packet
  a_r2_four_emits: assert property (@(posedge clk) disable iff (!rstN)
    (beat && fourStream) |=> outValidQ);
  // R9: a configuration error blocks the input
  a_r9_cfg_blocks: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |-> !inReady);
endmodule

// File: rtl/hbr_dpath.sv
module hbr_dpath
  import hbr_pkg::*;
#(
  parameter int SW = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  hbrStrobe_t            strb,
  input  logic [SLOTS*SW-1:0]   inSamples,
  input  logic [SLOTS*SELW-1:0] routeSel,
  output logic                  syncHit,
  output logic [SLOTS*SW-1:0]   outPacket
);
  localparam int PAIRW = 2 * SW;

  logic [SW-1:0]    smp   [SLOTS];
  logic [SELW-1:0]  route [SLOTS];
  logic [SW-1:0]    outQ  [SLOTS];
  logic [PAIRW-1:0] work  [SUBPKTS-1];

  assign syncHit = (smp[0][SW-1 -: 16] == SYNC_PA) && (smp[1][SW-1 -: 16] == SYNC_PB);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SUBPKTS - 1; i++) work[i] <= '0;
    end else if (strb.beat && !strb.four && strb.slot != 2'd3) begin
      work[strb.slot] <= {smp[0], smp[1]};
    end
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    assign smp[g] = inSamples[g*SW +: SW];
    assign outPacket[g*SW +: SW] = outQ[g];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        route[g] <= SELW'(g);
      else if (strb.routeLoad)
        route[g] <= routeSel[g*SELW +: SELW];
    end

    logic [SW-1:0] oneVal;
    if (g >= SLOTS - 2) begin : g_last
      assign oneVal = smp[g - (SLOTS - 2)];
    end else if (g % 2 == 0) begin : g_left
      assign oneVal = work[g/2][PAIRW-1:SW];
    end else begin : g_right
      assign oneVal = work[g/2][SW-1:0];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        outQ[g] <= '0;
      else if (strb.emit)
        outQ[g] <= strb.four ? smp[route[g]] : oneVal;
    end

    // R3: a route load takes its code from the select port
    a_r3_route_load: assert property (@(posedge clk) disable iff (!rstN)
      strb.routeLoad |=> route[g] == $past(routeSel[g*SELW +: SELW]));
  end
endmodule

// File: rtl/hbr_subpacket_assembler.sv
module hbr_subpacket_assembler
  import hbr_pkg::*;
#(
  parameter int SW = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            fourStream,
  input  logic            bpmMode,
  input  logic            mclkEn,
  input  logic            syncCtrl,
  input  logic            routeLoad,
  input  logic [23:0]     routeSel,
  input  logic            inValid,
  input  logic [8*SW-1:0] inSamples,
  output logic            inReady,
  output logic            outValid,
  output logic [8*SW-1:0] outPacket,
  input  logic            outReady,
  output logic            cfgErr
);
  hbrStrobe_t strb;
  logic       syncHit;

  hbr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .outReady(outReady),
    .fourStream(fourStream), .bpmMode(bpmMode), .mclkEn(mclkEn),
    .syncCtrl(syncCtrl), .routeLoad(routeLoad), .syncHit(syncHit),
    .inReady(inReady), .outValid(outValid), .cfgErr(cfgErr), .strb(strb)
  );

  hbr_dpath #(.SW(SW)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .inSamples(inSamples),
    .routeSel(routeSel), .syncHit(syncHit), .outPacket(outPacket)
  );

  // R8: a stalled packet stays valid and unchanged
  a_r8_hold_packet: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outPacket)));
  // R8: no beat is taken while the output is stalled
  a_r8_stall_input: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |-> !inReady);
endmodule

// File: tb/tb_hbr_subpacket_assembler.sv
module tb_hbr_subpacket_assembler;
  localparam int SW = 16;
  localparam logic [15:0] PA = 16'hF872;
  localparam logic [15:0] PB = 16'h4E1F;

  logic clk = 0, rstN = 0;
  logic fourStream = 1, bpmMode = 0, mclkEn = 0, syncCtrl = 0, routeLoad = 0;
  logic [23:0] routeSel = '0;
  logic inValid = 0, outReady = 1;
  logic [8*SW-1:0] inSamples = '0;
  logic inReady, outValid, cfgErr;
  logic [8*SW-1:0] outPacket;

  always #5 clk = ~clk;

  hbr_subpacket_assembler #(.SW(SW)) dut (
    .clk(clk), .rstN(rstN), .fourStream(fourStream), .bpmMode(bpmMode),
    .mclkEn(mclkEn), .syncCtrl(syncCtrl), .routeLoad(routeLoad),
    .routeSel(routeSel), .inValid(inValid), .inSamples(inSamples),
    .inReady(inReady), .outValid(outValid), .outPacket(outPacket),
    .outReady(outReady), .cfgErr(cfgErr)
  );

  int errors = 0, checks = 0;
  string curReq = "R1";

  // behavioural reference state
  logic        mOutValid, mArmed, mPrevSync;
  logic [15:0] mOut[8];
  int          mRoute[8];
  logic [15:0] partial[$];

  function automatic logic [15:0] smpOf(int k);
    return inSamples[k*SW +: SW];
  endfunction

  task automatic check(string req, string what, logic [127:0] got, logic [127:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got=%0h exp=%0h", req, what, got, exp);
    end
  endtask

  task automatic modelStep();
    logic cfg, rdy, rise, beat, emit;
    logic [15:0] pkt[8];
    if (!rstN) begin
      mOutValid = 0; mArmed = 0; mPrevSync = 0;
      for (int k = 0; k < 8; k++) begin mOut[k] = '0; mRoute[k] = k; end
      partial.delete();
      return;
    end
    cfg  = bpmMode && !mclkEn;
    rdy  = !cfg && (!mOutValid || outReady);
    rise = syncCtrl && !mPrevSync;
    beat = inValid && rdy;
    emit = 0;
    for (int k = 0; k < 8; k++) pkt[k] = '0;
    if (beat) begin
      if (fourStream) begin
        for (int k = 0; k < 8; k++) pkt[k] = smpOf(mRoute[k]);
        emit = 1;
      end else begin
        if (mArmed && smpOf(0) == PA && smpOf(1) == PB) begin
          partial.delete();
          mArmed = 0;
        end
        partial.push_back(smpOf(0));
        partial.push_back(smpOf(1));
        if (partial.size() == 8) begin
          for (int k = 0; k < 8; k++) pkt[k] = partial[k];
          partial.delete();
          emit = 1;
        end
      end
    end
    if (fourStream) partial.delete();
    if (emit) begin
      for (int k = 0; k < 8; k++) mOut[k] = pkt[k];
      mOutValid = 1;
    end else if (outReady) mOutValid = 0;
    if (rise) mArmed = 1;
    mPrevSync = syncCtrl;
    if (routeLoad) for (int k = 0; k < 8; k++) mRoute[k] = int'(routeSel[k*3 +: 3]);
  endtask

  task automatic compareAll();
    logic expRdy;
    expRdy = !(bpmMode && !mclkEn) && (!mOutValid || outReady);
    check(curReq, "outValid", 128'(outValid), 128'(mOutValid));
    check(curReq, "inReady",  128'(inReady),  128'(expRdy));
    check("R9",   "cfgErr",   128'(cfgErr),   128'(bpmMode && !mclkEn));
    if (mOutValid)
      for (int k = 0; k < 8; k++)
        check(curReq, $sformatf("slot%0d", k), 128'(outPacket[k*SW +: SW]), 128'(mOut[k]));
  endtask

  task automatic tick();
    @(posedge clk);
    modelStep();
    @(negedge clk);
    compareAll();
  endtask

  task automatic randData();
    inSamples = {$urandom, $urandom, $urandom, $urandom};
  endtask

  task automatic sendPair(logic [15:0] l, logic [15:0] r);
    randData();
    inSamples[15:0]  = l;
    inSamples[31:16] = r;
    inValid = 1;
    tick();
    inValid = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [127:0] held;
    // R1 reset state
    curReq = "R1";
    tick(); tick();
    rstN = 1;
    tick();
    check("R1", "reset outValid", 128'(outValid), 128'(0));
    check("R1", "reset inReady", 128'(inReady), 128'(1));

    // R2 four-stream with identity routes
    curReq = "R2";
    fourStream = 1;
    for (int i = 0; i < 6; i++) begin randData(); inValid = 1; tick(); end
    inValid = 0; tick();

    // R3 reversed route codes, then a swap pattern
    curReq = "R3";
    for (int k = 0; k < 8; k++) routeSel[k*3 +: 3] = 3'(7 - k);
    routeLoad = 1; randData(); inValid = 1; tick();
    routeLoad = 0;
    for (int i = 0; i < 4; i++) begin randData(); tick(); end
    for (int k = 0; k < 8; k++) routeSel[k*3 +: 3] = 3'(k ^ 1);
    routeLoad = 1; tick(); routeLoad = 0;
    randData(); tick();
    check("R3", "slot0 from code 1", 128'(outPacket[15:0]), 128'(inSamples[31:16]));
    inValid = 0; tick();

    // R8 stall holds packet and blocks input
    curReq = "R8";
    randData(); inValid = 1; tick();
    outReady = 0;
    held = outPacket;
    for (int i = 0; i < 4; i++) begin randData(); tick(); end
    check("R8", "held packet", outPacket, held);
    check("R8", "inReady stalled", 128'(inReady), 128'(0));
    outReady = 1;
    for (int i = 0; i < 3; i++) begin randData(); tick(); end
    inValid = 0; tick();

    // R10 continuous throughput
    curReq = "R10";
    for (int i = 0; i < 8; i++) begin
      randData(); inValid = 1; tick();
      check("R10", "inReady streaming", 128'(inReady), 128'(1));
    end
    inValid = 0; tick();

    // R4 one-stream packing
    curReq = "R4";
    fourStream = 0;
    for (int i = 0; i < 12; i++) sendPair(16'(i * 3 + 1), 16'(i * 5 + 2));
    tick();

    // R5 arm and align
    curReq = "R5";
    sendPair(16'h1111, 16'h2222);
    sendPair(16'h3333, 16'h4444);
    syncCtrl = 1; tick();
    sendPair(PA, PB);
    for (int i = 0; i < 3; i++) sendPair(16'(100 + i), 16'(200 + i));
    check("R5", "Pa in sub0 left", 128'(outPacket[15:0]), 128'(PA));
    check("R5", "Pb in sub0 right", 128'(outPacket[31:16]), 128'(PB));

    // R7 period of eight beats keeps alignment
    curReq = "R7";
    for (int rep = 0; rep < 3; rep++) begin
      sendPair(PA, PB);
      for (int i = 0; i < 3; i++) sendPair(16'(rep * 16 + i), 16'(rep * 16 + i + 8));
      check("R7", "Pa stays in sub0", 128'(outPacket[15:0]), 128'(PA));
      for (int i = 0; i < 4; i++) sendPair(16'(500 + i), 16'(600 + i));
    end

    // R6 holding 1, then falling, never rearms
    curReq = "R6";
    for (int pass = 0; pass < 2; pass++) begin
      if (pass == 1) begin syncCtrl = 0; tick(); end
      sendPair(16'h0A0A, 16'h0B0B);
      sendPair(PA, PB);
      sendPair(16'h0C0C, 16'h0D0D);
      sendPair(16'h0E0E, 16'h0F0F);
      check("R6", "Pa left at sub1", 128'(outPacket[2*SW +: SW]), 128'(PA));
    end

    // R9 configuration error
    curReq = "R9";
    fourStream = 1; bpmMode = 1; mclkEn = 0;
    randData(); inValid = 1;
    for (int i = 0; i < 3; i++) tick();
    check("R9", "cfgErr set", 128'(cfgErr), 128'(1));
    check("R9", "input blocked", 128'(inReady), 128'(0));
    mclkEn = 1;
    tick(); tick();
    check("R9", "cfgErr clear", 128'(cfgErr), 128'(0));
    inValid = 0; tick();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule